// File: doc/BRIEF.md
# VME Master Address and Modifier Generator

This block converts one processor access into the address, address-modifier and data lanes of a VMEbus master cycle. Two address paths exist. Processor addresses below 256 MB go through a window: a stored modifier byte and a stored high-address byte supply the upper address bits, the byte order, the interrupt-acknowledge flag and four of the six address-modifier lines. Processor addresses of 256 MB and above are mapped directly, and the top address bits encode the VME address space and byte order.

The block also reorders write-data bytes for big-endian transfers. It flags accesses that cannot complete as one indivisible bus cycle, so that the caller can split them. Every output is registered and becomes valid one clock after the request. Arbitration, data strobes and the acknowledge/error handshake belong to other blocks.

Top module: `vme_addr_gen`

## Requirements
- R1: A request with `req_valid` high at a rising edge produces `out_valid` high after that edge, together with its results. Without a request, `out_valid` is low after the edge.
- R2: Synchronous active-high reset clears both configuration bytes and every output to zero.
- R3: A windowed access is one whose `cpu_addr[31:28]` is 0. For it, `vme_addr` is {high byte, modifier bits 7:6, `cpu_addr[21:0]`}.
- R4: On the windowed path, `vme_am` is {mod[3], mod[2], 1, mod[1], mod[0], ~mod[0]}. On every path, AM3 is 1 and AM0 is the inverse of AM1.
- R5: On the windowed path, modifier bit 5 selects the byte order: 0 is little endian and 1 is big endian.
- R6: When modifier bit 4 is set, a windowed access becomes an interrupt-acknowledge cycle. `vme_iack` is 1, `vme_addr[3:1]` equals `cpu_addr[3:1]` (the level times 2), and all other address bits are 0.
- R7: Direct A16/A24 mapping uses the top nibble. Nibble 1 gives A16, little endian, AM 0x29, and address {16'b0, `cpu_addr[15:0]`}. Nibble 2 gives A24, little endian, AM 0x39. Nibble 3 gives A24, big endian, AM 0x39. Both A24 cases use address {8'b0, `cpu_addr[23:0]`}. The direct path never sets `vme_iack`.
- R8: Size is coded 0=D08, 1=D16, 2=D32, 3=wider. In little-endian mode and for D08, data passes unchanged. A big-endian D16 swaps bytes 0 and 1 and leaves bytes 2 and 3 unchanged. A big-endian D32 or wider access reverses all four bytes.
- R9: Direct A32 mapping applies when `cpu_addr[31:30]` is nonzero, and `vme_addr` is {2'b00, `cpu_addr[29:0]`}. Code 01 gives little endian with AM 0x09. Code 10 gives big endian with AM 0x09. Code 11 gives little endian with AM 0x0D.
- R10: `non_atomic` is 1 for size 3, for a D16 at an odd address, and for a D32 whose `cpu_addr[1:0]` is nonzero. Otherwise it is 0.
- R11: A configuration write affects requests captured at later edges only. A request captured at the same edge as the write uses the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mod_we | input | 1 | Write enable for the modifier byte |
| cfg_hi_we | input | 1 | Write enable for the high-address byte |
| cfg_wdata | input | 8 | Configuration write value |
| req_valid | input | 1 | Processor access present |
| cpu_addr | input | 32 | Processor address |
| req_size | input | 2 | Transfer size code |
| wdata | input | 32 | Processor write data |
| out_valid | output | 1 | Results below are valid |
| vme_addr | output | 32 | VME address lines |
| vme_am | output | 6 | VME address-modifier lines |
| vme_iack | output | 1 | Interrupt-acknowledge cycle |
| vme_data | output | 32 | Byte-ordered write data |
| non_atomic | output | 1 | Access must be split by the caller |

## Verification
The assertions assume that `req_valid`, `cpu_addr`, `req_size` and `wdata` are stable around the capturing edge. They also assume that each check on the A32 or direct paths sees a request whose top bits select that path. The stimulus drives every input on the falling edge and holds it through the next rising edge. Because every 32-bit address falls on some defined path, random addresses never leave the legal space. Direct cases also cover the window boundary at nibble 0/1, same-edge configuration writes, and interrupt-acknowledge reads at each level.

// File: rtl/vag_pkg.sv
package vag_pkg;
  localparam int ADDR_W = 32;
  localparam int CFG_W  = 8;
  localparam int AM_W   = 6;

  typedef enum logic [1:0] {
    SZ_D08  = 2'd0,
    SZ_D16  = 2'd1,
    SZ_D32  = 2'd2,
    SZ_WIDE = 2'd3
  } xfer_size_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [AM_W-1:0]   am;
    logic              iack;
    logic              big_end;
  } vme_cyc_t;

  localparam logic [AM_W-1:0] AM_A16_USR  = 6'h29;
  localparam logic [AM_W-1:0] AM_A24_USR  = 6'h39;
  localparam logic [AM_W-1:0] AM_A32_USR  = 6'h09;
  localparam logic [AM_W-1:0] AM_A32_SUP  = 6'h0D;
endpackage

// File: rtl/vag_regs.sv
module vag_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mod_we,
  input  logic         hi_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mod_q,
  output logic [W-1:0] hi_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mod_q <= '0;
      hi_q  <= '0;
    end else begin
      if (mod_we) mod_q <= wdata;
      if (hi_we)  hi_q  <= wdata;
    end
  end
endmodule

// File: rtl/vag_decode.sv
module vag_decode
  import vag_pkg::*;
#(
  parameter int WIN_LOW_BITS = 22
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [CFG_W-1:0]  mod_q,
  input  logic [CFG_W-1:0]  hi_q,
  output vme_cyc_t          cyc
);
  localparam int NIB_LSB = ADDR_W - 4;
  localparam int A32_KEEP = ADDR_W - 2;

  logic [3:0] nib;
  assign nib = cpu_addr[ADDR_W-1:NIB_LSB];

  always_comb begin
    cyc = '0;
    if (nib == 4'd0) begin
      cyc.am      = {mod_q[3], mod_q[2], 1'b1, mod_q[1], mod_q[0], ~mod_q[0]};
      cyc.big_end = mod_q[5];
      if (mod_q[4]) begin
        cyc.iack      = 1'b1;
        cyc.addr      = '0;
        cyc.addr[3:1] = cpu_addr[3:1];
      end else begin
        cyc.addr = {hi_q, mod_q[7:6], cpu_addr[WIN_LOW_BITS-1:0]};
      end
    end else if (nib[3:2] == 2'b00) begin
      unique case (nib[1:0])
        2'd1: begin
          cyc.addr = {16'h0, cpu_addr[15:0]};
          cyc.am   = AM_A16_USR;
        end
        2'd2: begin
          cyc.addr = {8'h0, cpu_addr[23:0]};
          cyc.am   = AM_A24_USR;
        end
        default: begin
          cyc.addr    = {8'h0, cpu_addr[23:0]};
          cyc.am      = AM_A24_USR;
          cyc.big_end = 1'b1;
        end
      endcase
    end else begin
      cyc.addr = {2'b00, cpu_addr[A32_KEEP-1:0]};
      unique case (nib[3:2])
        2'd1:    cyc.am = AM_A32_USR;
        2'd2: begin
          cyc.am      = AM_A32_USR;
          cyc.big_end = 1'b1;
        end
        default: cyc.am = AM_A32_SUP;
      endcase
    end
  end
endmodule

// File: rtl/vag_swap.sv
module vag_swap
  import vag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              big_end,
  input  xfer_size_e        size,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int NB = DATA_W / 8;

  logic [DATA_W-1:0] rev;
  logic [DATA_W-1:0] half;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign rev[g*8 +: 8] = din[(NB-1-g)*8 +: 8];
    if (g < 2) begin : g_pair
      assign half[g*8 +: 8] = din[(1-g)*8 +: 8];
    end else begin : g_keep
      assign half[g*8 +: 8] = din[g*8 +: 8];
    end
  end

  always_comb begin
    if (!big_end || size == SZ_D08) dout = din;
    else if (size == SZ_D16)        dout = half;
    else                            dout = rev;
  end
endmodule

// File: rtl/vag_atomic.sv
module vag_atomic
  import vag_pkg::*;
(
  input  logic [1:0]  addr_lo,
  input  xfer_size_e  size,
  output logic        split
);
  always_comb begin
    unique case (size)
      SZ_WIDE: split = 1'b1;
      SZ_D32:  split = (addr_lo != 2'b00);
      SZ_D16:  split = addr_lo[0];
      default: split = 1'b0;
    endcase
  end
endmodule

// File: rtl/vme_addr_gen.sv
module vme_addr_gen
  import vag_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int WIN_LOW_BITS = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_mod_we,
  input  logic              cfg_hi_we,
  input  logic [7:0]        cfg_wdata,
  input  logic              req_valid,
  input  logic [31:0]       cpu_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] wdata,
  output logic              out_valid,
  output logic [31:0]       vme_addr,
  output logic [5:0]        vme_am,
  output logic              vme_iack,
  output logic [DATA_W-1:0] vme_data,
  output logic              non_atomic
);
  logic [CFG_W-1:0]  mod_q, hi_q;
  vme_cyc_t          cyc;
  logic [DATA_W-1:0] sw_data;
  logic              split;
  xfer_size_e        sz;

  assign sz = xfer_size_e'(req_size);

  vag_regs #(.W(CFG_W)) u_regs (
    .clk(clk), .rst(rst), .mod_we(cfg_mod_we), .hi_we(cfg_hi_we),
    .wdata(cfg_wdata), .mod_q(mod_q), .hi_q(hi_q)
  );

  vag_decode #(.WIN_LOW_BITS(WIN_LOW_BITS)) u_dec (
    .cpu_addr(cpu_addr), .mod_q(mod_q), .hi_q(hi_q), .cyc(cyc)
  );

  vag_swap #(.DATA_W(DATA_W)) u_swap (
    .big_end(cyc.big_end), .size(sz), .din(wdata), .dout(sw_data)
  );

  vag_atomic u_atom (
    .addr_lo(cpu_addr[1:0]), .size(sz), .split(split)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      vme_addr   <= '0;
      vme_am     <= '0;
      vme_iack   <= 1'b0;
      vme_data   <= '0;
      non_atomic <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        vme_addr   <= cyc.addr;
        vme_am     <= cyc.am;
        vme_iack   <= cyc.iack;
        vme_data   <= sw_data;
        non_atomic <= split;
      end
    end
  end
endmodule

// File: rtl/vag_checker.sv
module vag_checker (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [31:0] cpu_addr,
  input logic [1:0]  req_size,
  input logic [31:0] wdata,
  input logic        out_valid,
  input logic [31:0] vme_addr,
  input logic [5:0]  vme_am,
  input logic        vme_iack,
  input logic [31:0] vme_data,
  input logic        non_atomic
);
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);
  p_am3_high_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> vme_am[3]);
  p_am0_inv_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (vme_am[0] != vme_am[1]));
  p_iack_addr_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && vme_iack) |-> (vme_addr[31:4] == 28'h0 && !vme_addr[0]));
  p_direct_noiack_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cpu_addr[31:28] != 4'h0) |=> !vme_iack);
  p_byte_pass_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'd0) |=> (vme_data == $past(wdata)));
  p_a32_pass_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cpu_addr[31:30] != 2'b00) |=>
      (vme_addr[31:30] == 2'b00 && vme_addr[29:0] == $past(cpu_addr[29:0])));
  p_wide_split_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'd3) |=> non_atomic);
endmodule

bind vme_addr_gen vag_checker u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .cpu_addr(cpu_addr),
  .req_size(req_size), .wdata(wdata), .out_valid(out_valid),
  .vme_addr(vme_addr), .vme_am(vme_am), .vme_iack(vme_iack),
  .vme_data(vme_data), .non_atomic(non_atomic)
);

// File: tb/tb_vme_addr_gen.sv
`timescale 1ns/1ps
module tb_vme_addr_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_mod_we, cfg_hi_we;
  logic [7:0]  cfg_wdata;
  logic        req_valid;
  logic [31:0] cpu_addr;
  logic [1:0]  req_size;
  logic [31:0] wdata;
  logic        out_valid;
  logic [31:0] vme_addr;
  logic [5:0]  vme_am;
  logic        vme_iack;
  logic [31:0] vme_data;
  logic        non_atomic;

  int checks = 0;
  int bad    = 0;
  logic [7:0] m_mod = 8'h0;
  logic [7:0] m_hi  = 8'h0;

  always #2.5 clk = ~clk;

  vme_addr_gen dut (
    .clk(clk), .rst(rst), .cfg_mod_we(cfg_mod_we), .cfg_hi_we(cfg_hi_we),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .cpu_addr(cpu_addr),
    .req_size(req_size), .wdata(wdata), .out_valid(out_valid),
    .vme_addr(vme_addr), .vme_am(vme_am), .vme_iack(vme_iack),
    .vme_data(vme_data), .non_atomic(non_atomic)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(
    input  logic [31:0] a, input logic [1:0] s, input logic [31:0] d,
    input  logic [7:0] md, input logic [7:0] hb,
    output logic [31:0] ea, output logic [5:0] eam, output logic ei,
    output logic [31:0] ed, output logic ena);
    logic be;
    ei = 1'b0; be = 1'b0;
    if (a[31:28] == 4'h0) begin
      eam = {md[3], md[2], 1'b1, md[1], md[0], ~md[0]};
      be  = md[5];
      if (md[4]) begin ei = 1'b1; ea = {28'h0, a[3:1], 1'b0}; end
      else ea = {hb, md[7:6], a[21:0]};
    end else if (a[31:28] == 4'h1) begin
      ea = {16'h0, a[15:0]}; eam = 6'h29;
    end else if (a[31:28] == 4'h2) begin
      ea = {8'h0, a[23:0]}; eam = 6'h39;
    end else if (a[31:28] == 4'h3) begin
      ea = {8'h0, a[23:0]}; eam = 6'h39; be = 1'b1;
    end else begin
      ea = {2'b00, a[29:0]};
      eam = (a[31:30] == 2'b11) ? 6'h0D : 6'h09;
      be  = (a[31:30] == 2'b10);
    end
    if (!be || s == 2'd0) ed = d;
    else if (s == 2'd1)   ed = {d[31:16], d[7:0], d[15:8]};
    else                  ed = {d[7:0], d[15:8], d[23:16], d[31:24]};
    ena = (s == 2'd3) || (s == 2'd2 && a[1:0] != 2'b00) || (s == 2'd1 && a[0]);
  endfunction

  task automatic check_out(input string tag, input logic [31:0] a,
                           input logic [1:0] s, input logic [31:0] d,
                           input logic [7:0] md, input logic [7:0] hb);
    logic [31:0] ea, ed; logic [5:0] eam; logic ei, ena;
    model(a, s, d, md, hb, ea, eam, ei, ed, ena);
    chk({tag, " R1 valid"}, {31'h0, out_valid}, 32'h1);
    chk({tag, " addr"}, vme_addr, ea);
    chk({tag, " R4 am"}, {26'h0, vme_am}, {26'h0, eam});
    chk({tag, " R6 iack"}, {31'h0, vme_iack}, {31'h0, ei});
    chk({tag, " R8 data"}, vme_data, ed);
    chk({tag, " R10 split"}, {31'h0, non_atomic}, {31'h0, ena});
  endtask

  task automatic do_req(input string tag, input logic [31:0] a,
                        input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; cpu_addr = a; req_size = s; wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check_out(tag, a, s, d, m_mod, m_hi);
  endtask

  task automatic cfg(input logic wm, input logic wh, input logic [7:0] v);
    @(negedge clk);
    cfg_mod_we = wm; cfg_hi_we = wh; cfg_wdata = v;
    @(negedge clk);
    cfg_mod_we = 1'b0; cfg_hi_we = 1'b0;
    if (wm) m_mod = v;
    if (wh) m_hi = v;
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int dummy;
    dummy = $urandom(32'd4711);
    rst = 1'b1; cfg_mod_we = 1'b0; cfg_hi_we = 1'b0; cfg_wdata = 8'h0;
    req_valid = 1'b0; cpu_addr = 32'h0; req_size = 2'd0; wdata = 32'h0;
    repeat (4) @(negedge clk);
    chk("R2 reset valid", {31'h0, out_valid}, 32'h0);
    chk("R2 reset addr", vme_addr, 32'h0);
    chk("R2 reset am", {26'h0, vme_am}, 32'h0);
    rst = 1'b0;
    // R2: configuration bytes are zero after reset
    do_req("R2 R3 window after reset", 32'h0ABC_DEF0, 2'd2, 32'h1122_3344);
    @(negedge clk);
    chk("R1 idle valid", {31'h0, out_valid}, 32'h0);

    // R3/R5 windowed address and byte order
    cfg(1'b0, 1'b1, 8'hA5);
    cfg(1'b1, 1'b0, 8'hC0 | 8'h0A);
    do_req("R3 window LE", 32'h0123_4567, 2'd2, 32'hA1B2_C3D4);
    cfg(1'b1, 1'b0, 8'h6F);
    do_req("R5 window BE D32", 32'h0FFF_FFFC, 2'd2, 32'hA1B2_C3D4);
    do_req("R5 R8 window BE D16", 32'h0000_0002, 2'd1, 32'hA1B2_C3D4);
    do_req("R8 window BE D08", 32'h0000_0003, 2'd0, 32'hA1B2_C3D4);

    // R6 interrupt acknowledge at each level
    cfg(1'b1, 1'b0, 8'hD3);
    for (int lvl = 1; lvl < 8; lvl++)
      do_req("R6 iack", {28'h0, 3'(lvl), 1'b0} | 32'h0ABC_DEF0, 2'd0, 32'h0000_00FF);

    // R7 direct A16/A24, boundary around the window
    do_req("R7 A16", 32'h1234_5678, 2'd1, 32'h0000_BEEF);
    do_req("R7 A24 low edge", 32'h2000_0000, 2'd2, 32'hCAFE_F00D);
    do_req("R7 A24 top", 32'h20FF_FFFC, 2'd2, 32'hCAFE_F00D);
    do_req("R7 A24 BE", 32'h3012_3456, 2'd2, 32'hCAFE_F00D);
    do_req("R3 window top", 32'h0FFF_FFFF, 2'd0, 32'h55);
    do_req("R7 first direct", 32'h1000_0000, 2'd0, 32'h55);

    // R9 direct A32 modes
    do_req("R9 A32 LE", 32'h7FFF_FFFC, 2'd2, 32'h0102_0304);
    do_req("R9 A32 BE", 32'hBFFF_FFFC, 2'd2, 32'h0102_0304);
    do_req("R9 A32 sup", 32'hC000_0010, 2'd1, 32'h0102_0304);

    // R10 alignment cases
    do_req("R10 odd D16", 32'h2000_0001, 2'd1, 32'h0);
    do_req("R10 D32 mis", 32'h2000_0002, 2'd2, 32'h0);
    do_req("R10 wide", 32'h4000_0000, 2'd3, 32'h89AB_CDEF);

    // R11 same-edge configuration write uses old value
    @(negedge clk);
    cfg_mod_we = 1'b1; cfg_wdata = 8'h00; cfg_hi_we = 1'b1;
    req_valid = 1'b1; cpu_addr = 32'h0000_0006; req_size = 2'd0; wdata = 32'h77;
    @(negedge clk);
    cfg_mod_we = 1'b0; cfg_hi_we = 1'b0; req_valid = 1'b0;
    check_out("R11 same edge", 32'h0000_0006, 2'd0, 32'h77, m_mod, m_hi);
    m_mod = 8'h00; m_hi = 8'h00;
    do_req("R11 next edge", 32'h0000_0006, 2'd0, 32'h77);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      if ($urandom % 8 == 0) cfg(1'b1, 1'b0, 8'($urandom));
      if ($urandom % 8 == 0) cfg(1'b0, 1'b1, 8'($urandom));
      a = $urandom;
      if ($urandom % 3 == 0) a[31:28] = 4'h0;
      do_req("R3 R7 R9 random", a, 2'($urandom), $urandom);
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule